// File: doc/BRIEF.md
# Microcoded Single-Address Accumulator Processor

This block is a 20-bit processor with one address per instruction. It fetches instruction words from a word-addressed memory and executes each one as a short run of micro-steps. A package function maps the current micro-step and the stored function code to a micro-order. That micro-order names the memory action, the arithmetic action and the control-section action for the step.

The arithmetic section holds a 40-bit accumulator made of a high word and a low word. It also holds a multiplier register and a 40-bit shift register that is wired permanently to one side of the adder-subtractor. The control section holds the program counter, the effective-address register and a loop counter. The loop counter is loaded from a constant (0, 1 or 18) or from the address field, and it counts down to end the multiply loop and the shift loops.

A surrounding system places a program in memory and releases reset. Characters enter through a strobed input port. Words leave through a registered output port that gives a one-cycle valid pulse.

Top module: `cpu20_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the block presents a read at address 0 with no write, no input strobe and no output pulse. The accumulator starts at zero after reset.
- R2: Code 1 (add) and code 2 (subtract) add the word at address n to the high accumulator word, or subtract it from that word. The low word is left unchanged. The block takes three cycles for either code.
- R3: Code 3 copies the word at address n into the low accumulator word and leaves the high word unchanged.
- R4: Code 4 multiplies the low word, read as signed, by the word at address n, which must have bit 19 clear. The 40-bit signed product replaces the whole accumulator. The multiply runs as 19 shift-and-add steps while the counter runs down from 18 to 0.
- R5: Code 5 and code 6 write the high accumulator word to address n. Code 5 also clears both accumulator words after the write.
- R6: Code 7 shifts the 40-bit accumulator right by n+1 places and copies the sign bit into the vacated places. Code 8 shifts it left by n+1 places and fills with zeros. Either shift moves one place per cycle.
- R7: Code 9 loads the program counter with n when bit 19 of the high word is set. Otherwise the next instruction follows in sequence, and this includes a high word of zero.
- R8: Codes 0, 12, 13, 14 and 15 change neither the accumulator nor memory. They only advance to the next instruction.
- R9: Code 10 pulses the input strobe and writes the character, zero-extended, to address n in the same cycle. Code 11 reads address n, and in the next cycle the block pulses the output valid and presents the word.
- R10: An instruction word holds its function code in bits 19:16 and n in bits 9:0. Each fetch adds 1 to the program counter. A read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | ADDR_W (10) | Word address of the memory access |
| mem_rd | output | 1 | Read strobe; mem_rdata must be valid in the same cycle |
| mem_wr | output | 1 | Write strobe; the write is taken at the clock edge |
| mem_wdata | output | W (20) | Write data |
| mem_rdata | input | W (20) | Read data |
| in_req | output | 1 | Input strobe; in_data is consumed in this cycle |
| in_data | input | CHAR_W (8) | Input character |
| out_valid | output | 1 | One-cycle pulse when out_data carries a new word |
| out_data | output | W (20) | Output word |

## Verification
The low accumulator word has no direct path to the ports, so the multiply and shift results are hard to observe. Each vector program ends by storing the high word. It then shifts left by 20 places and stores again, which turns the low word into a stored word. The multiply vectors include a negative multiplicand and a multiplier with all 19 usable bits set, so that every loop step adds. A long right shift of 24 places carries bits across the boundary between the two words.

// File: rtl/cpu20_pkg.sv
package cpu20_pkg;

    localparam int WORD_W        = 20;
    localparam int ADDR_W_DEF    = 10;
    localparam int CHAR_W_DEF    = 8;
    localparam int OPC_W         = 4;
    localparam int MUL_LOOP_INIT = 18;

    localparam logic [OPC_W-1:0] OP_ADD    = 4'd1;
    localparam logic [OPC_W-1:0] OP_SUB    = 4'd2;
    localparam logic [OPC_W-1:0] OP_LDLO   = 4'd3;
    localparam logic [OPC_W-1:0] OP_MUL    = 4'd4;
    localparam logic [OPC_W-1:0] OP_STCLR  = 4'd5;
    localparam logic [OPC_W-1:0] OP_STKEEP = 4'd6;
    localparam logic [OPC_W-1:0] OP_SHR    = 4'd7;
    localparam logic [OPC_W-1:0] OP_SHL    = 4'd8;
    localparam logic [OPC_W-1:0] OP_BRNEG  = 4'd9;
    localparam logic [OPC_W-1:0] OP_IN     = 4'd10;
    localparam logic [OPC_W-1:0] OP_OUT    = 4'd11;

    typedef enum logic [3:0] {
        ST_FETCH, ST_ADD_LD, ST_ADD_EX, ST_LDLO, ST_MUL_SET, ST_MUL_LOOP,
        ST_STORE, ST_SH_SET, ST_SH_LOOP, ST_BR, ST_IN, ST_OUT
    } step_e;

    typedef enum logic [2:0] {M_IDLE, M_RD_PC, M_RD_EA, M_WR_ACC, M_WR_IN} mem_e;

    typedef enum logic [3:0] {
        A_HOLD, A_LOAD_D, A_ADD, A_SUB, A_LOAD_LO, A_MUL_SET, A_MUL_STEP,
        A_CLEAR, A_SHR, A_SHL
    } aop_e;

    typedef enum logic [2:0] {C_HOLD, C_FETCH, C_CNT_MUL, C_CNT_EA, C_CNT_DEC, C_BRANCH} cop_e;

    typedef struct packed {
        mem_e mem;
        aop_e aop;
        cop_e cop;
    } uorder_t;

    // Dispatch: the first micro-step of each function code.
    function automatic step_e entry_step(input logic [OPC_W-1:0] op);
        case (op)
            OP_ADD, OP_SUB:       return ST_ADD_LD;
            OP_LDLO:              return ST_LDLO;
            OP_MUL:               return ST_MUL_SET;
            OP_STCLR, OP_STKEEP:  return ST_STORE;
            OP_SHR, OP_SHL:       return ST_SH_SET;
            OP_BRNEG:             return ST_BR;
            OP_IN:                return ST_IN;
            OP_OUT:               return ST_OUT;
            default:              return ST_FETCH;
        endcase
    endfunction

    // Micro-order matrix: step and stored function code select the actions.
    function automatic uorder_t micro_order(input step_e s, input logic [OPC_W-1:0] op);
        uorder_t u;
        u.mem = M_IDLE;
        u.aop = A_HOLD;
        u.cop = C_HOLD;
        case (s)
            ST_FETCH:    begin u.mem = M_RD_PC;  u.cop = C_FETCH; end
            ST_ADD_LD:   begin u.mem = M_RD_EA;  u.aop = A_LOAD_D; end
            ST_ADD_EX:   u.aop = (op == OP_SUB) ? A_SUB : A_ADD;
            ST_LDLO:     begin u.mem = M_RD_EA;  u.aop = A_LOAD_LO; end
            ST_MUL_SET:  begin u.mem = M_RD_EA;  u.aop = A_MUL_SET; u.cop = C_CNT_MUL; end
            ST_MUL_LOOP: begin u.aop = A_MUL_STEP; u.cop = C_CNT_DEC; end
            ST_STORE:    begin u.mem = M_WR_ACC; u.aop = (op == OP_STCLR) ? A_CLEAR : A_HOLD; end
            ST_SH_SET:   u.cop = C_CNT_EA;
            ST_SH_LOOP:  begin u.aop = (op == OP_SHL) ? A_SHL : A_SHR; u.cop = C_CNT_DEC; end
            ST_BR:       u.cop = C_BRANCH;
            ST_IN:       u.mem = M_WR_IN;
            ST_OUT:      u.mem = M_RD_EA;
            default:     u.mem = M_IDLE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/cpu20_seq.sv
module cpu20_seq
    import cpu20_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] fetch_op,
    input  logic             cnt_zero,
    output step_e            step
);

    step_e step_nxt;

    always_comb begin
        case (step)
            ST_FETCH:                 step_nxt = entry_step(fetch_op);
            ST_ADD_LD:                step_nxt = ST_ADD_EX;
            ST_MUL_SET:               step_nxt = ST_MUL_LOOP;
            ST_SH_SET:                step_nxt = ST_SH_LOOP;
            ST_MUL_LOOP, ST_SH_LOOP:  step_nxt = cnt_zero ? ST_FETCH : step;
            default:                  step_nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step <= ST_FETCH;
        else     step <= step_nxt;
    end

endmodule

// File: rtl/cpu20_ctl.sv
module cpu20_ctl
    import cpu20_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  cop_e              cop,
    input  logic [OPC_W-1:0]  fetch_op,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              acc_neg,
    output logic [OPC_W-1:0]  ir_op,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] ea,
    output logic              cnt_zero
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cadd;

    // Control adder: one side is always the counter; the other side is a constant or n.
    always_comb begin
        case (cop)
            C_CNT_MUL: cadd = CNT_W'(MUL_LOOP_INIT);
            C_CNT_EA:  cadd = CNT_W'(ea);
            C_CNT_DEC: cadd = cnt - CNT_W'(1);
            default:   cadd = cnt;
        endcase
    end

    assign cnt_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_op <= '0;
            pc    <= '0;
            ea    <= '0;
            cnt   <= '0;
        end else begin
            cnt <= cadd;
            case (cop)
                C_FETCH: begin
                    ir_op <= fetch_op;
                    ea    <= fetch_addr;
                    pc    <= pc + ADDR_W'(1);
                end
                C_BRANCH: if (acc_neg) pc <= ea;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cpu20_arith.sv
module cpu20_arith
    import cpu20_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  aop_e         aop,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] acc_hi,
    output logic [W-1:0] acc_lo
);

    localparam int AW = 2 * W;

    logic [AW-1:0] acc;
    logic [AW-1:0] dreg;
    logic [W-1:0]  mreg;
    logic [AW-1:0] addsub;

    // The shift register is wired permanently to one side of the adder-subtractor.
    assign addsub = (aop == A_SUB) ? (acc - dreg) : (acc + dreg);
    assign acc_hi = acc[AW-1:W];
    assign acc_lo = acc[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            dreg <= '0;
            mreg <= '0;
        end else begin
            case (aop)
                A_LOAD_D:   dreg <= {mem_rdata, W'(0)};
                A_ADD,
                A_SUB:      acc <= addsub;
                A_LOAD_LO:  acc[W-1:0] <= mem_rdata;
                A_MUL_SET: begin
                    mreg <= mem_rdata;
                    dreg <= {{W{acc[W-1]}}, acc[W-1:0]};
                    acc  <= '0;
                end
                A_MUL_STEP: begin
                    if (mreg[0]) acc <= addsub;
                    dreg <= {dreg[AW-2:0], 1'b0};
                    mreg <= {1'b0, mreg[W-1:1]};
                end
                A_CLEAR:    acc <= '0;
                A_SHR:      acc <= {acc[AW-1], acc[AW-1:1]};
                A_SHL:      acc <= {acc[AW-2:0], 1'b0};
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cpu20_core.sv
module cpu20_core
    import cpu20_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int CHAR_W = CHAR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    output logic              in_req,
    input  logic [CHAR_W-1:0] in_data,
    output logic              out_valid,
    output logic [W-1:0]      out_data
);

    localparam int CNT_W = (ADDR_W > 5) ? ADDR_W : 5;

    step_e             step;
    uorder_t           uo;
    logic [OPC_W-1:0]  ir_op;
    logic [OPC_W-1:0]  fetch_op;
    logic [ADDR_W-1:0] fetch_addr;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ea;
    logic              cnt_zero;
    logic [W-1:0]      acc_hi;
    logic [W-1:0]      acc_lo;

    assign fetch_op   = mem_rdata[W-1 -: OPC_W];
    assign fetch_addr = mem_rdata[ADDR_W-1:0];
    assign uo         = micro_order(step, ir_op);

    cpu20_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .fetch_op (fetch_op),
        .cnt_zero (cnt_zero),
        .step     (step)
    );

    cpu20_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cop        (uo.cop),
        .fetch_op   (fetch_op),
        .fetch_addr (fetch_addr),
        .acc_neg    (acc_hi[W-1]),
        .ir_op      (ir_op),
        .pc         (pc),
        .ea         (ea),
        .cnt_zero   (cnt_zero)
    );

    cpu20_arith #(.W(W)) u_arith (
        .clk       (clk),
        .rst       (rst),
        .aop       (uo.aop),
        .mem_rdata (mem_rdata),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo)
    );

    assign mem_addr  = (uo.mem == M_RD_PC) ? pc : ea;
    assign mem_rd    = (uo.mem == M_RD_PC) || (uo.mem == M_RD_EA);
    assign mem_wr    = (uo.mem == M_WR_ACC) || (uo.mem == M_WR_IN);
    assign in_req    = (uo.mem == M_WR_IN);
    assign mem_wdata = in_req ? W'(in_data) : acc_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (step == ST_OUT);
            if (step == ST_OUT) out_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/cpu20_core_chk.sv
module cpu20_core_chk
    import cpu20_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input logic              clk,
    input logic              rst,
    input step_e             step,
    input logic [OPC_W-1:0]  ir_op,
    input logic [ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0] ea,
    input logic              cnt_zero,
    input logic [W-1:0]      acc_hi,
    input logic [W-1:0]      acc_lo,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              in_req,
    input logic              out_valid
);

    p_first_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_rd && !mem_wr && mem_addr == '0));

    p_rd_wr_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && step == ST_FETCH) |-> (pc == ADDR_W'($past(pc) + 1'b1)));

    p_mul_exit_r4: assert property (@(posedge clk) disable iff (rst)
        (step == ST_MUL_LOOP && cnt_zero) |=> (step == ST_FETCH));

    p_store_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && step == ST_STORE && ir_op == OP_STCLR) |-> (acc_hi == '0 && acc_lo == '0));

    p_branch_taken_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && step == ST_BR && acc_hi[W-1]) |-> (pc == $past(ea)));

    p_in_writes_r9: assert property (@(posedge clk) disable iff (rst)
        in_req |-> mem_wr);

    p_out_after_read_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(mem_rd));

endmodule

bind cpu20_core cpu20_core_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .ir_op     (ir_op),
    .pc        (pc),
    .ea        (ea),
    .cnt_zero  (cnt_zero),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .in_req    (in_req),
    .out_valid (out_valid)
);

// File: tb/sim_cpu20_core.sv
module sim_cpu20_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  mem_addr;
    logic        mem_rd, mem_wr, in_req, out_valid;
    logic [19:0] mem_wdata, mem_rdata, out_data;
    logic [7:0]  in_data = 8'h5A;

    logic [19:0] mem [0:1023];
    int checks = 0;
    int failures = 0;
    int out_cnt, in_cnt;
    logic [19:0] first_out;

    always #5 clk = ~clk;

    cpu20_core u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_req(in_req), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (rst) begin
            out_cnt <= 0;
            in_cnt  <= 0;
            first_out <= '0;
        end else begin
            if (out_valid) begin
                if (out_cnt == 0) first_out <= out_data;
                out_cnt <= out_cnt + 1;
            end
            if (in_req) in_cnt <= in_cnt + 1;
        end
    end

    // Instruction word: code in 19:16, n in 9:0.
    function automatic logic [19:0] ins(input logic [3:0] op, input logic [9:0] n);
        return {op, 6'b0, n};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [19:0] act, input logic [19:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic prog_begin();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    task automatic prog_run();
        @(negedge clk);
        rst = 1'b0;
        repeat (250) @(negedge clk);
    endtask

    // Fields: op[113:110] n[109:100] lo[99:80] hi[79:60] m[59:40] exp_hi[39:20] exp_lo[19:0]
    localparam int NV = 11;
    localparam logic [113:0] VECS [0:NV-1] = '{
        {4'd1,  10'd50, 20'd5,       20'd100,     20'd23,      20'd123,     20'd5},       // R2 add
        {4'd2,  10'd50, 20'd0,       20'd10,      20'd30,      20'hFFFEC,   20'd0},       // R2 sub to negative
        {4'd3,  10'd50, 20'd7,       20'd9,       20'h12345,   20'd9,       20'h12345},   // R3
        {4'd4,  10'd50, 20'd1000,    20'h00055,   20'd3000,    20'd2,       20'hDC6C0},   // R4
        {4'd4,  10'd50, 20'hFFFFD,   20'd0,       20'd7,       20'hFFFFF,   20'hFFFEB},   // R4 negative
        {4'd4,  10'd50, 20'd2,       20'd0,       20'h7FFFF,   20'd0,       20'hFFFFE},   // R4 all bits
        {4'd7,  10'd3,  20'd0,       20'h00010,   20'd0,       20'd1,       20'd0},       // R6 right 4
        {4'd7,  10'd0,  20'd0,       20'hFFFF0,   20'd0,       20'hFFFF8,   20'd0},       // R6 sign fill
        {4'd8,  10'd0,  20'h80000,   20'd1,       20'd0,       20'd3,       20'd0},       // R6 left 1
        {4'd7,  10'd23, 20'd0,       20'h12345,   20'd0,       20'd0,       20'h01234},   // R6 right 24
        {4'd13, 10'd50, 20'd6,       20'd4,       20'd99,      20'd4,       20'd6}        // R8 unused code
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        // R1: during reset
        repeat (3) @(negedge clk);
        check(mem_rd && !mem_wr && mem_addr == 10'd0, "R1", "reset fetch addr", 20'(mem_addr), 20'd0);
        check(!out_valid && !in_req, "R1", "reset strobes", {18'd0, out_valid, in_req}, 20'd0);

        // Vector table: load lo, add hi, test order, store hi, shift low into high, store.
        for (int v = 0; v < NV; v++) begin
            logic [113:0] t;
            t = VECS[v];
            prog_begin();
            mem[0]  = ins(4'd3, 10'd48);
            mem[1]  = ins(4'd1, 10'd49);
            mem[2]  = ins(t[113:110], t[109:100]);
            mem[3]  = ins(4'd6, 10'd60);
            mem[4]  = ins(4'd8, 10'd19);
            mem[5]  = ins(4'd6, 10'd61);
            mem[48] = t[99:80];
            mem[49] = t[79:60];
            mem[50] = t[59:40];
            prog_run();
            check(mem[60] == t[39:20], $sformatf("R%0s", (t[113:110] == 4'd1 || t[113:110] == 4'd2) ? "2" :
                  t[113:110] == 4'd3 ? "3" : t[113:110] == 4'd4 ? "4" : t[113:110] == 4'd13 ? "8" : "6"),
                  $sformatf("vec%0d high", v), mem[60], t[39:20]);
            check(mem[61] == t[19:0], "R2/R3/R4/R6/R8 low", $sformatf("vec%0d low", v), mem[61], t[19:0]);
            check(mem[50] == t[59:40], "R8 operand untouched", $sformatf("vec%0d mem50", v), mem[50], t[59:40]);
        end

        // R5: store and clear, then store again
        prog_begin();
        mem[0] = ins(4'd1, 10'd49);
        mem[1] = ins(4'd5, 10'd60);
        mem[2] = ins(4'd6, 10'd61);
        mem[49] = 20'd77;
        prog_run();
        check(mem[60] == 20'd77, "R5", "store-clear value", mem[60], 20'd77);
        check(mem[61] == 20'd0, "R5", "cleared after code 5", mem[61], 20'd0);

        // R5: store without clear
        prog_begin();
        mem[0] = ins(4'd1, 10'd49);
        mem[1] = ins(4'd6, 10'd60);
        mem[2] = ins(4'd6, 10'd61);
        mem[49] = 20'd77;
        prog_run();
        check(mem[61] == 20'd77, "R5", "code 6 keeps acc", mem[61], 20'd77);

        // R7: negative high word takes the branch
        prog_begin();
        mem[0] = ins(4'd2, 10'd49);
        mem[1] = ins(4'd9, 10'd5);
        mem[2] = ins(4'd11, 10'd47);
        mem[5] = ins(4'd11, 10'd46);
        mem[46] = 20'h00111; mem[47] = 20'h00222; mem[49] = 20'd1;
        prog_run();
        check(first_out == 20'h00111, "R7", "branch taken", first_out, 20'h00111);

        // R7: positive high word falls through
        prog_begin();
        mem[0] = ins(4'd1, 10'd49);
        mem[1] = ins(4'd9, 10'd5);
        mem[2] = ins(4'd11, 10'd47);
        mem[5] = ins(4'd11, 10'd46);
        mem[46] = 20'h00111; mem[47] = 20'h00222; mem[49] = 20'd1;
        prog_run();
        check(first_out == 20'h00222, "R7", "positive falls through", first_out, 20'h00222);

        // R7: zero high word falls through
        prog_begin();
        mem[1] = ins(4'd9, 10'd5);
        mem[2] = ins(4'd11, 10'd47);
        mem[5] = ins(4'd11, 10'd46);
        mem[46] = 20'h00111; mem[47] = 20'h00222;
        prog_run();
        check(first_out == 20'h00222, "R7", "zero falls through", first_out, 20'h00222);

        // R9: input then output
        prog_begin();
        mem[0] = ins(4'd10, 10'd40);
        mem[1] = ins(4'd11, 10'd40);
        prog_run();
        check(mem[40] == 20'h0005A, "R9", "input stored", mem[40], 20'h0005A);
        check(first_out == 20'h0005A, "R9", "output word", first_out, 20'h0005A);
        check(in_cnt == 1, "R9", "one input strobe", 20'(in_cnt), 20'd1);
        check(out_cnt == 1, "R9", "one output pulse", 20'(out_cnt), 20'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule